// File: doc/BRIEF.md
# Tuner Synthesizer Control Receiver

This block is the write-only serial control port of a frequency-synthesizer tuner. A host writes it over a standard two-wire I2C bus. The block runs on a fast system clock that oversamples the bus clock and data lines. Each line passes through a synchronizer and a majority vote before any edge is detected.

A telegram opens with a START and a slave address. The address has five fixed high bits, two bits taken from a chip-select input and a write bit of zero. The data bytes that follow are sorted by content, not by a sub-address. The top bit of the first and of the third data byte decides whether that byte and the one after it carry the loop divider word or the control settings. A host can therefore update either register pair, both pairs in either order, or only part of a pair, and may end with a STOP after any byte.

The outputs are registers that drive the rest of the tuner:
- the 15-bit divider ratio,
- four loop-control flags: pump current, test routing, pump high-impedance and amplifier disable,
- three band-switch bits,
- four auxiliary port bits.

Top module: `tuner_i2c_regs`

## Requirements
- R1: Framing follows the bus rules. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. Data bits are taken on SCL rising edges. Bus activity that does not follow a START gets no acknowledge.
- R2: The address byte, MSB first, must equal 1,1,0,0,0,chip_sel[1],chip_sel[0],0. A matching byte is acknowledged.
- R3: When the address mismatches or its last bit is 1 (a read), no acknowledge is given. Every later byte is then ignored and the registers keep their values until the next START.
- R4: An acknowledge holds SDA low from the SCL falling edge after the eighth bit to the SCL falling edge that ends the ninth clock. SDA is not held low during the data bits.
- R5: A lead data byte (data position 1 or 3) with bit 7 = 0 loads divider bits 14..8 from its bits 6..0. The byte after it loads divider bits 7..0.
- R6: A lead data byte with bit 7 = 1 is a control byte. Bit 6 sets pump_hi_o, bit 5 sets test_route_o, bit 4 sets pump_hiz_o and bit 0 sets amp_off_o. The byte after it sets aux_o from its bits 7..4 and band_o from its bits 2..0. Its bit 3 is ignored.
- R7: The third data byte is judged again by its bit 7, so the two pairs may come in either order.
- R8: A STOP may follow any complete byte. Each byte's field updates at that byte's acknowledge, so a lone lead byte changes only its own fields.
- R9: The fifth and later data bytes of a telegram are acknowledged and change no register.
- R10: Synchronous reset sets the divider to 256 and every other output to 0. SDA is not pulled low while reset is held or after it is released.
- R11: A repeated START, with no STOP before it, restarts address reception and resets the data position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| chip_sel | input | 2 | Selectable address bits |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |
| div_word_o | output | 15 | Divider ratio |
| pump_hi_o | output | 1 | High charge-pump current |
| test_route_o | output | 1 | Route test signals to ports |
| pump_hiz_o | output | 1 | Charge pump high-impedance |
| amp_off_o | output | 1 | Disable tuning amplifier output |
| band_o | output | 3 | Band-switch outputs, 1 = active |
| aux_o | output | 4 | Auxiliary port outputs, 1 = active |

## Verification
The assertions assume that SDA changes only while the filtered SCL is low, except at START and STOP. They also assume that no SCL or SDA phase is shorter than the filter latency of a few clocks, so the two lines never cross the filter in the same cycle. The bench keeps to this. Every bus phase lasts ten system clocks, and the bench changes data at least ten clocks after a clock edge. The open-drain line is modelled as the AND of the bench drive and the inverted pull output, so the data filter sees the acknowledge as a real bus level.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int BYTE_W   = 8;
  localparam int DIV_W    = 15;
  localparam int BAND_W   = 3;
  localparam int AUX_W    = 4;
  localparam int SEL_W    = 2;
  localparam int PREFIX_W = BYTE_W - SEL_W - 1;
  localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11000;
  localparam logic [DIV_W-1:0]    DIV_RESET   = 15'd256;

  typedef enum logic [2:0] {
    RX_IDLE, RX_ADDR, RX_DATA, RX_ACK, RX_SKIP
  } rx_state_t;
endpackage

// File: rtl/tuner_line_filter.sv
module tuner_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   hist_q;

  function automatic logic vote(input logic [VOTE_TAPS-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < VOTE_TAPS; i++) if (v[i]) n++;
    return n > VOTE_TAPS / 2;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      dout   <= vote(hist_q);
    end
  end
endmodule

// File: rtl/tuner_i2c_rx.sv
module tuner_i2c_rx
  import tuner_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [SEL_W-1:0]  chip_sel,
  output logic              sda_pull,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q,
  output logic              frame_start
);
  localparam int CNT_W = $clog2(BYTE_W);

  rx_state_t         state;
  logic              scl_q, sda_q, full;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [BYTE_W-1:0] own_addr;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  assign own_addr = {ADDR_PREFIX, chip_sel, 1'b0};

  always_ff @(posedge clk) begin
    byte_stb    <= 1'b0;
    frame_start <= 1'b0;
    if (rst) begin
      state    <= RX_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      full     <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_q   <= '0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_c) begin
        state       <= RX_ADDR;
        bit_cnt     <= '0;
        full        <= 1'b0;
        sda_pull    <= 1'b0;
        frame_start <= 1'b1;
      end else if (stop_c) begin
        state    <= RX_IDLE;
        full     <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          RX_ADDR, RX_DATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == CNT_W'(BYTE_W - 1)) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (state == RX_DATA) begin
                sda_pull <= 1'b1;
                byte_stb <= 1'b1;
                byte_q   <= shreg;
                state    <= RX_ACK;
              end else if (shreg == own_addr) begin
                sda_pull <= 1'b1;
                state    <= RX_ACK;
              end else begin
                state <= RX_SKIP;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= RX_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: the pull changes only at an SCL fall or at framing events
  a_r4_ack_on_scl_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));
  // R3: a rejected telegram never acknowledges
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
    (state == RX_SKIP) |-> !sda_pull);
  // R9: every delivered byte comes with an acknowledge
  a_r9_byte_acked: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> sda_pull);
  // R10: line released after reset
  a_r10_release_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !sda_pull);
endmodule

// File: rtl/tuner_reg_sorter.sv
module tuner_reg_sorter
  import tuner_i2c_pkg::*;
#(
  parameter int MAX_DATA = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_q,
  output logic [DIV_W-1:0]  div_word,
  output logic              pump_hi,
  output logic              test_route,
  output logic              pump_hiz,
  output logic              amp_off,
  output logic [BAND_W-1:0] band,
  output logic [AUX_W-1:0]  aux
);
  localparam int POS_W = $clog2(MAX_DATA + 1);
  localparam int HI_W  = DIV_W - BYTE_W;

  logic [POS_W-1:0] pos;
  logic             lead_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= '0;
      lead_ctl   <= 1'b0;
      div_word   <= DIV_RESET;
      pump_hi    <= 1'b0;
      test_route <= 1'b0;
      pump_hiz   <= 1'b0;
      amp_off    <= 1'b0;
      band       <= '0;
      aux        <= '0;
    end else if (frame_start) begin
      pos <= '0;
    end else if (byte_stb && pos < POS_W'(MAX_DATA)) begin
      pos <= pos + 1'b1;
      if (!pos[0]) begin
        lead_ctl <= byte_q[BYTE_W-1];
        if (byte_q[BYTE_W-1]) begin
          pump_hi    <= byte_q[6];
          test_route <= byte_q[5];
          pump_hiz   <= byte_q[4];
          amp_off    <= byte_q[0];
        end else begin
          div_word[DIV_W-1:BYTE_W] <= byte_q[HI_W-1:0];
        end
      end else if (lead_ctl) begin
        aux  <= byte_q[BYTE_W-1 -: AUX_W];
        band <= byte_q[BAND_W-1:0];
      end else begin
        div_word[BYTE_W-1:0] <= byte_q;
      end
    end
  end

  // R9: data position saturates
  a_r9_pos_saturates: assert property (@(posedge clk) disable iff (rst)
    pos <= POS_W'(MAX_DATA));
  // R5: divider moves only after a delivered byte
  a_r5_div_needs_byte: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_word) |-> $past(byte_stb));
  // R6: control and ports move only after a delivered byte
  a_r6_ctrl_needs_byte: assert property (@(posedge clk) disable iff (rst)
    !$stable({pump_hi, test_route, pump_hiz, amp_off, band, aux}) |-> $past(byte_stb));
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3,
  parameter int MAX_DATA    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] chip_sel,
  output logic             sda_pull_o,
  output logic [DIV_W-1:0] div_word_o,
  output logic             pump_hi_o,
  output logic             test_route_o,
  output logic             pump_hiz_o,
  output logic             amp_off_o,
  output logic [BAND_W-1:0] band_o,
  output logic [AUX_W-1:0] aux_o
);
  localparam int LINES = 2;

  logic [LINES-1:0]  raw, clean;
  logic              byte_stb, frame_start;
  logic [BYTE_W-1:0] byte_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    tuner_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS  (VOTE_TAPS)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw[g]),
      .dout(clean[g])
    );
  end

  tuner_i2c_rx u_rx (
    .clk        (clk),
    .rst        (rst),
    .scl_f      (clean[1]),
    .sda_f      (clean[0]),
    .chip_sel   (chip_sel),
    .sda_pull   (sda_pull_o),
    .byte_stb   (byte_stb),
    .byte_q     (byte_q),
    .frame_start(frame_start)
  );

  tuner_reg_sorter #(.MAX_DATA(MAX_DATA)) u_sort (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .byte_stb   (byte_stb),
    .byte_q     (byte_q),
    .div_word   (div_word_o),
    .pump_hi    (pump_hi_o),
    .test_route (test_route_o),
    .pump_hiz   (pump_hiz_o),
    .amp_off    (amp_off_o),
    .band       (band_o),
    .aux        (aux_o)
  );
endmodule

// File: tb/tuner_i2c_regs_tb.sv
module tuner_i2c_regs_tb_top;
  localparam int Q  = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [1:0]      sel;
    logic [7:0]      addr;
    logic [2:0]      n;
    logic [0:4][7:0] d;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'b00, 8'hC0, 3'd2, {8'h12, 8'h34, 8'h00, 8'h00, 8'h00}},
    '{2'b01, 8'hC2, 3'd4, {8'hCE, 8'hA5, 8'h7F, 8'hFF, 8'h00}},
    '{2'b10, 8'hC4, 3'd4, {8'h05, 8'h00, 8'hBF, 8'h5A, 8'h00}},
    '{2'b11, 8'hC6, 3'd1, {8'h2A, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{2'b11, 8'hC4, 3'd2, {8'h01, 8'h01, 8'h00, 8'h00, 8'h00}},
    '{2'b00, 8'hC1, 3'd1, {8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    '{2'b00, 8'hC0, 3'd5, {8'h01, 8'h02, 8'h8E, 8'h00, 8'h33}},
    '{2'b10, 8'hC4, 3'd3, {8'hF0, 8'h77, 8'h03, 8'h00, 8'h00}}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic drv = 1'b1;
  logic [1:0] chip_sel = 2'b00;
  logic sda_line;
  logic sda_pull_o, pump_hi_o, test_route_o, pump_hiz_o, amp_off_o;
  logic [14:0] div_word_o;
  logic [2:0] band_o;
  logic [3:0] aux_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [14:0] m_div = 15'd256;
  logic [3:0]  m_ctl = '0;
  logic [3:0]  m_aux = '0;
  logic [2:0]  m_band = '0;
  int          m_pos = 0;
  logic        m_lead = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = drv & ~sda_pull_o;

  tuner_i2c_regs dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .chip_sel(chip_sel),
    .sda_pull_o(sda_pull_o), .div_word_o(div_word_o), .pump_hi_o(pump_hi_o),
    .test_route_o(test_route_o), .pump_hiz_o(pump_hiz_o), .amp_off_o(amp_off_o),
    .band_o(band_o), .aux_o(aux_o)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int k);
    repeat (k * Q) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    check(req, {17'b0, div_word_o}, {17'b0, m_div});
    check(req, {28'b0, pump_hi_o, test_route_o, pump_hiz_o, amp_off_o}, {28'b0, m_ctl});
    check(req, {25'b0, aux_o, band_o}, {25'b0, m_aux, m_band});
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (m_pos < 4) begin
      if (m_pos % 2 == 0) begin
        m_lead = b[7];
        if (b[7]) m_ctl = {b[6], b[5], b[4], b[0]};
        else m_div[14:8] = b[6:0];
      end else if (m_lead) begin
        m_aux = b[7:4];
        m_band = b[2:0];
      end else begin
        m_div[7:0] = b;
      end
      m_pos++;
    end
  endtask

  task automatic bus_start();
    drv = 1'b1; wq(1); scl = 1'b1; wq(1);
    drv = 1'b0; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    drv = 1'b0; wq(1); scl = 1'b1; wq(1);
    drv = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic early, output logic ackd,
                           output logic late);
    early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      drv = b[i]; wq(1); scl = 1'b1; wq(1);
      if (sda_pull_o) early = 1'b1;
      wq(1); scl = 1'b0; wq(1);
    end
    drv = 1'b1; wq(1); scl = 1'b1; wq(1);
    ackd = ~sda_line;
    wq(1); scl = 1'b0; wq(1);
    late = sda_pull_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic e, a, l, ok;
    repeat (5) @(negedge clk);
    check("R10 reset pull", {31'b0, sda_pull_o}, 32'd0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check_regs("R10 reset values");

    // R1: a byte without a START is not acknowledged
    chip_sel = 2'b00;
    send_byte(8'hC0, e, a, l);
    check("R1 no START no ack", {31'b0, a}, 32'd0);
    check_regs("R1 regs unchanged");

    for (int v = 0; v < NV; v++) begin
      chip_sel = VECS[v].sel;
      wq(1);
      ok = (VECS[v].addr == {5'b11000, VECS[v].sel, 1'b0});
      bus_start();
      m_pos = 0;
      send_byte(VECS[v].addr, e, a, l);
      check(ok ? "R2 address ack" : "R3 address rejected", {31'b0, a}, {31'b0, ok});
      for (int k = 0; k < int'(VECS[v].n); k++) begin
        send_byte(VECS[v].d[k], e, a, l);
        check(ok ? "R9 data ack" : "R3 data ignored", {31'b0, a}, {31'b0, ok});
        check("R4 no pull during bits", {31'b0, e}, 32'd0);
        check("R4 released after ninth clock", {31'b0, l}, 32'd0);
        if (ok) model_byte(VECS[v].d[k]);
      end
      bus_stop();
      check_regs("R5 R6 R7 R8 R9 register contents");
    end

    // R11: repeated START after a rejected address
    chip_sel = 2'b01;
    bus_start();
    send_byte(8'hC0, e, a, l);
    check("R3 wrong select", {31'b0, a}, 32'd0);
    bus_start();
    m_pos = 0;
    send_byte(8'hC2, e, a, l);
    check("R11 repeated start ack", {31'b0, a}, 32'd1);
    send_byte(8'h11, e, a, l); model_byte(8'h11);
    send_byte(8'h22, e, a, l); model_byte(8'h22);
    bus_stop();
    check_regs("R11 regs after repeated start");

    // R8: lone control lead byte changes only its own flags
    bus_start();
    m_pos = 0;
    send_byte(8'hC2, e, a, l);
    send_byte(8'h8F, e, a, l); model_byte(8'h8F);
    bus_stop();
    check_regs("R8 lone control byte");

    // R10: reset after activity
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_div = 15'd256; m_ctl = '0; m_aux = '0; m_band = '0;
    repeat (3) @(negedge clk);
    check_regs("R10 reset after use");
    check("R10 line released", {31'b0, sda_line}, 32'd1);

    summary();
    $finish;
  end
endmodule